// File: doc/BRIEF.md
# Correlator Channel Accumulation Status Flags

This block keeps the per-channel status bits of a 12-channel integrate-and-dump correlator. Each channel reports two single-cycle events. A dump pulse means a fresh accumulation has landed. A consume pulse means the host has read that channel's prompt accumulation. From these events the block keeps two live flags per channel: "fresh data waiting" and "data overrun". An overrun is an accumulation that was replaced before anyone read it. Two level inputs per channel are also sampled: the late/early code indication and the measurement-missed indication.

The host never sees the live flags directly. It writes to one global latch address, and the value written does not matter. At that moment every live flag of every channel is copied into a set of snapshot registers. The host then polls the snapshots over a 16-bit read port, so a tracking loop can run without interrupts. A write to a channel's own clear address, again with any data, clears that channel's bits in the fresh, overrun and late/early snapshots.

The host port is a plain register bus: one write strobe with an address, and a read path decoded from the address alone. It has no handshake and no back-pressure, because every access completes in the cycle it is presented.

Top module: `acc_status_flags`

## Requirements
- R1: A dump pulse on channel n sets that channel's live fresh flag. If the fresh flag is already set when the dump is sampled, the live overrun flag is set too.
- R2: A consume pulse on channel n clears both of its live flags. If a dump arrives in the same cycle, the dump's update applies and the consume has no effect.
- R3: A write to address 0x200 copies the live fresh flags, the live overrun flags, the late/early inputs and the measurement-missed inputs of all channels into the snapshots at the same clock edge. The write data is ignored. A write to any other status address does not latch.
- R4: Snapshots keep their value through any live activity until the next latch write or clear write.
- R5: A write to address n*0x10+0x04 clears bit n of the fresh, overrun and late/early snapshots. The write data is ignored. The measurement snapshot and the other channels are left unchanged.
- R6: The read data depends combinationally on the address. Address 0x200 returns late/early (1 = late), 0x204 returns measurement missed, 0x208 returns fresh and 0x20C returns overrun. Bit n of each register is channel n.
- R7: Read bits 15:12 are always zero. An address outside the four status registers reads as zero.
- R8: While rst_n is low, all live flags and snapshots are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dump_i | input | 12 | Per-channel dump event pulse |
| consume_i | input | 12 | Per-channel pulse: host read prompt accumulation |
| code_late_i | input | 12 | Per-channel late (1) / early (0) level |
| meas_miss_i | input | 12 | Per-channel measurement-missed level |
| host_addr | input | 10 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data (ignored) |
| host_rdata | output | 16 | Host read data for host_addr |

## Verification
The live flags change at the edge that samples a dump or consume pulse. A latch or clear write changes the snapshots at the very edge that samples the write, and a read reflects the address in the same cycle with no register on the path. The bench therefore drives every input on the falling edge and lets one rising edge pass for each event. It issues the latch write on the following falling edge and reads the snapshots a falling edge later, comparing shortly after each address change. A live flag therefore only becomes visible through a latch written at least one edge after its event, and the vector table is laid out with that spacing.

// File: rtl/acc_stat_pkg.sv
package acc_stat_pkg;
  localparam int unsigned NCH_DEF   = 12;
  localparam int unsigned DW_DEF    = 16;
  localparam int unsigned AW_DEF    = 10;
  localparam int unsigned STAT_BASE = 'h200;
  localparam int unsigned CH_STRIDE = 'h10;
  localparam int unsigned CLR_OFS   = 'h04;

  typedef enum logic [2:0] {
    RS_NONE, RS_LATE, RS_MEAS, RS_FRESH, RS_OVER
  } rsel_e;
endpackage

// File: rtl/acc_live_flag.sv
module acc_live_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic dump,
  input  logic consume,
  output logic fresh_q,
  output logic over_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh_q <= 1'b0;
      over_q  <= 1'b0;
    end else if (dump) begin
      // dump wins over a same-cycle consume
      fresh_q <= 1'b1;
      over_q  <= over_q | fresh_q;
    end else if (consume) begin
      fresh_q <= 1'b0;
      over_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_host_dec.sv
module acc_host_dec
  import acc_stat_pkg::*;
#(
  parameter int unsigned NCH = NCH_DEF,
  parameter int unsigned AW  = AW_DEF
) (
  input  logic [AW-1:0]  addr,
  input  logic           wr,
  output logic           latch_p,
  output logic [NCH-1:0] clr_vec,
  output rsel_e          rsel
);
  localparam logic [AW-1:0] A_LATE  = AW'(STAT_BASE + 'h0);
  localparam logic [AW-1:0] A_MEAS  = AW'(STAT_BASE + 'h4);
  localparam logic [AW-1:0] A_FRESH = AW'(STAT_BASE + 'h8);
  localparam logic [AW-1:0] A_OVER  = AW'(STAT_BASE + 'hC);

  assign latch_p = wr && (addr == A_LATE);

  for (genvar c = 0; c < NCH; c++) begin : g_clr
    localparam logic [AW-1:0] A_CLR = AW'(c * CH_STRIDE + CLR_OFS);
    assign clr_vec[c] = wr && (addr == A_CLR);
  end

  always_comb begin
    unique case (addr)
      A_LATE:  rsel = RS_LATE;
      A_MEAS:  rsel = RS_MEAS;
      A_FRESH: rsel = RS_FRESH;
      A_OVER:  rsel = RS_OVER;
      default: rsel = RS_NONE;
    endcase
  end
endmodule

// File: rtl/acc_snap_bank.sv
module acc_snap_bank #(
  parameter int unsigned NCH = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           latch_p,
  input  logic [NCH-1:0] clr_vec,
  input  logic [NCH-1:0] live_fresh,
  input  logic [NCH-1:0] live_over,
  input  logic [NCH-1:0] live_late,
  input  logic [NCH-1:0] live_meas,
  output logic [NCH-1:0] snap_fresh,
  output logic [NCH-1:0] snap_over,
  output logic [NCH-1:0] snap_late,
  output logic [NCH-1:0] snap_meas
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_fresh <= '0;
      snap_over  <= '0;
      snap_late  <= '0;
      snap_meas  <= '0;
    end else if (latch_p) begin
      snap_fresh <= live_fresh;
      snap_over  <= live_over;
      snap_late  <= live_late;
      snap_meas  <= live_meas;
    end else if (|clr_vec) begin
      snap_fresh <= snap_fresh & ~clr_vec;
      snap_over  <= snap_over  & ~clr_vec;
      snap_late  <= snap_late  & ~clr_vec;
    end
  end
endmodule

// File: rtl/acc_status_flags.sv
module acc_status_flags
  import acc_stat_pkg::*;
#(
  parameter int unsigned NCH = NCH_DEF,
  parameter int unsigned DW  = DW_DEF,
  parameter int unsigned AW  = AW_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dump_i,
  input  logic [NCH-1:0] consume_i,
  input  logic [NCH-1:0] code_late_i,
  input  logic [NCH-1:0] meas_miss_i,
  input  logic [AW-1:0]  host_addr,
  input  logic           host_wr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata
);
  localparam int unsigned PADW = DW - NCH;

  logic [NCH-1:0] live_fresh, live_over;
  logic [NCH-1:0] snap_fresh, snap_over, snap_late, snap_meas;
  logic [NCH-1:0] clr_vec;
  logic           latch_p;
  rsel_e          rsel;
  logic [NCH-1:0] rvec;
  logic           unused_wdata;

  assign unused_wdata = ^host_wdata;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    acc_live_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .dump    (dump_i[c]),
      .consume (consume_i[c]),
      .fresh_q (live_fresh[c]),
      .over_q  (live_over[c])
    );
  end

  acc_host_dec #(.NCH(NCH), .AW(AW)) u_dec (
    .addr    (host_addr),
    .wr      (host_wr),
    .latch_p (latch_p),
    .clr_vec (clr_vec),
    .rsel    (rsel)
  );

  acc_snap_bank #(.NCH(NCH)) u_snap (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_p    (latch_p),
    .clr_vec    (clr_vec),
    .live_fresh (live_fresh),
    .live_over  (live_over),
    .live_late  (code_late_i),
    .live_meas  (meas_miss_i),
    .snap_fresh (snap_fresh),
    .snap_over  (snap_over),
    .snap_late  (snap_late),
    .snap_meas  (snap_meas)
  );

  always_comb begin
    unique case (rsel)
      RS_LATE:  rvec = snap_late;
      RS_MEAS:  rvec = snap_meas;
      RS_FRESH: rvec = snap_fresh;
      RS_OVER:  rvec = snap_over;
      default:  rvec = '0;
    endcase
  end

  if (PADW > 0) begin : g_pad
    assign host_rdata = {{PADW{1'b0}}, rvec};
  end else begin : g_nopad
    assign host_rdata = rvec[DW-1:0];
  end
endmodule

// File: rtl/acc_status_chk.sv
module acc_status_chk #(
  parameter int unsigned NCH = 12,
  parameter int unsigned DW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dump_i,
  input logic [NCH-1:0] consume_i,
  input logic [NCH-1:0] live_fresh,
  input logic [NCH-1:0] live_over,
  input logic           latch_p,
  input logic [NCH-1:0] clr_vec,
  input logic [NCH-1:0] snap_fresh,
  input logic [NCH-1:0] snap_over,
  input logic [NCH-1:0] snap_late,
  input logic [DW-1:0]  host_rdata
);
  p_dump_sets_fresh_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|dump_i) |=> ((live_fresh & $past(dump_i)) == $past(dump_i)));

  p_overrun_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dump_i & live_fresh)) |=>
      ((live_over & $past(dump_i & live_fresh)) == $past(dump_i & live_fresh)));

  p_consume_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(consume_i & ~dump_i)) |=>
      (((live_fresh | live_over) & $past(consume_i & ~dump_i)) == '0));

  p_latch_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_p |=> (snap_fresh == $past(live_fresh)) && (snap_over == $past(live_over)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_p && clr_vec == '0) |=> ($stable(snap_fresh) && $stable(snap_over) && $stable(snap_late)));

  p_clr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec) && !(latch_p && |clr_vec));

  p_clr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> (((snap_fresh | snap_over | snap_late) & $past(clr_vec)) == '0));

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[DW-1:NCH] == '0);
endmodule

bind acc_status_flags acc_status_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dump_i     (dump_i),
  .consume_i  (consume_i),
  .live_fresh (live_fresh),
  .live_over  (live_over),
  .latch_p    (latch_p),
  .clr_vec    (clr_vec),
  .snap_fresh (snap_fresh),
  .snap_over  (snap_over),
  .snap_late  (snap_late),
  .host_rdata (host_rdata)
);

// File: tb/sim_acc_status_flags.sv
`timescale 1ns/1ps
module sim_acc_status_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] dump_i = '0, consume_i = '0, code_late_i = '0, meas_miss_i = '0;
  logic [9:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_status_flags u0 (.*);

  typedef struct packed {
    logic [11:0] dmp, cns, late, meas, x_fresh, x_over;
  } vec_t;

  localparam vec_t TBL [7] = '{
    '{12'h001, 12'h000, 12'h0A5, 12'h000, 12'h001, 12'h000},
    '{12'h003, 12'h000, 12'hFFF, 12'h123, 12'h003, 12'h001},
    '{12'h000, 12'h001, 12'h000, 12'h800, 12'h002, 12'h000},
    '{12'hF00, 12'h002, 12'h5A5, 12'h0FF, 12'hF00, 12'h000},
    '{12'h800, 12'h000, 12'h801, 12'hFFF, 12'hF00, 12'h800},
    '{12'h020, 12'h000, 12'h3C3, 12'h00F, 12'hF20, 12'h800},
    '{12'h020, 12'h020, 12'hC0F, 12'h3C3, 12'hF20, 12'h820}
  };

  task automatic chk_rd(input logic [9:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    host_addr = a;
    #1;
    total++;
    if (host_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, host_rdata, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk_rd(10'h200, 16'h0, "R8");
    chk_rd(10'h208, 16'h0, "R8");
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R3 R6: vector walk
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      dump_i = TBL[i].dmp; consume_i = TBL[i].cns;
      code_late_i = TBL[i].late; meas_miss_i = TBL[i].meas;
      @(negedge clk);
      dump_i = '0; consume_i = '0;
      wr(10'h200, 16'(i * 16'h1357));
      chk_rd(10'h208, {4'h0, TBL[i].x_fresh}, "R1/R2 fresh");
      chk_rd(10'h20C, {4'h0, TBL[i].x_over},  "R1/R2 overrun");
      chk_rd(10'h200, {4'h0, TBL[i].late},    "R3 late");
      chk_rd(10'h204, {4'h0, TBL[i].meas},    "R3 meas");
    end

    // R4: live activity without latch leaves snapshots alone
    @(negedge clk); dump_i = 12'h001; code_late_i = '0;
    @(negedge clk); dump_i = '0;
    chk_rd(10'h208, 16'h0F20, "R4");
    chk_rd(10'h200, 16'h0C0F, "R4");

    // R5: clear channel 11, data ignored
    wr(10'h0B4, 16'hFFFF);
    chk_rd(10'h208, 16'h0720, "R5 fresh");
    chk_rd(10'h20C, 16'h0020, "R5 overrun");
    chk_rd(10'h200, 16'h040F, "R5 late");
    chk_rd(10'h204, 16'h03C3, "R5 meas kept");

    // R3: write to a non-latch status address does not latch
    wr(10'h208, 16'h0000);
    chk_rd(10'h208, 16'h0720, "R3 no latch");

    // R7: unmapped reads
    chk_rd(10'h210, 16'h0, "R7");
    chk_rd(10'h100, 16'h0, "R7");

    // R3: latch again
    wr(10'h200, 16'hA5A5);
    chk_rd(10'h208, 16'h0F21, "R3 relatch");
    chk_rd(10'h20C, 16'h0820, "R3 relatch");
    chk_rd(10'h200, 16'h0000, "R3 relatch");

    // R8: mid-run reset clears live and snapshots
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk_rd(10'h208, 16'h0, "R8 snap");
    wr(10'h200, 16'h0);
    chk_rd(10'h20C, 16'h0, "R8 live");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule